// File: doc/BRIEF.md
# Read sense-pulse sequencer

This block drives the read side of a memory that stands in for a host's magnetic core store. The host's storage buffer register can only be set, one bit at a time, by an active-low pulse on that bit's sense line. When the host begins a read cycle it raises a strobe. The block latches the 16-bit word that the local memory presents at that moment. It computes one odd-parity bit for each 8-bit half of the word; parity is never stored. It then plays out a timed burst of set pulses.

Data bits are pulsed two at a time, in ascending pairs, over eight equal steps. All eight steps fit inside a window that opens after the host's first clock step and closes before its third, where the host may start copying the register. The two parity pulses follow once the data window has closed. A bit whose value is 0 gets no pulse. Every delay and width is a parameter counted in system clock cycles. With the defaults and a 100 MHz clock, the first step starts 45 cycles in, each step is 6 cycles with a 5-cycle pulse, and parity follows the window directly.

Top module: `rd_sense_seq`

## Requirements
- R1: Parity bit h (h=0 for data bits 7:0, h=1 for bits 15:8) is 1 exactly when its half holds an even number of 1s, so that the half plus its parity bit has an odd count. It is computed from the word latched at each read.
- R2: All sense outputs are active-low (0 = pulse). Data output b (sense_n_o[b]) and parity output h (par_n_o[h]) pulse only when the bit's value is 1; a bit that is 0 stays at 1 throughout the sequence.
- R3: Let edge 0 be the clock edge that samples the starting strobe. The pulse for data bit b goes low after edge START_DLY+(b/2)*STEP_CYC+1 and stays low for exactly PULSE_CYC cycles.
- R4: Data bits are issued in pairs in ascending order: bits 2k and 2k+1 in step k, for k = 0 to 7. No more than two data outputs are ever low at once.
- R5: Every data pulse starts no earlier than edge START_DLY+1 and has ended by edge START_DLY+8*STEP_CYC+1, the close of the data window.
- R6: A parity pulse goes low after edge START_DLY+8*STEP_CYC+PAR_GAP+1, lasts PAR_CYC cycles, and never overlaps a data pulse.
- R7: A strobe that arrives while a sequence is running is ignored. The word is latched only at the start, so later changes on rd_data_i have no effect on the pulses of that sequence.
- R8: After a sequence the block starts again only once the strobe has been seen low while idle. A strobe held high past the end does not start a second sequence.
- R9: busy_o is 1 from edge 0 through edge SEQ_END, where SEQ_END = START_DLY+8*STEP_CYC+PAR_GAP+PAR_CYC. After the next edge busy_o is 0 and done_o is 1 for exactly one cycle. While busy_o is 0, every sense and parity output is 1.
- R10: While rst_ni is low, all sense and parity outputs are 1 and busy_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_strobe_i | input | 1 | Host read-cycle start strobe |
| rd_data_i | input | 16 | Word presented by the local memory |
| sense_n_o | output | 16 | Active-low set pulses for the data bits |
| par_n_o | output | 2 | Active-low set pulses for the two parity bits |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when a sequence ends |

## Verification
The assertions check the following on every cycle. No pulse goes to a 0 bit. At most two data lines are ever low. A data pulse appears only inside the data window, and parity never overlaps data. A parity pulse appears only for a half whose count is even. The latched word holds while busy, and the outputs are quiet when idle. Only the bench scenarios show the exact start edge and width of each pulse, the ascending pair order, the busy and done timing, and that odd parity holds for each chosen word. They also show that a mid-sequence strobe with new data and a strobe held high both leave the burst unchanged and start nothing new.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int unsigned HALF_W = 8;

  function automatic logic odd_par(input logic [HALF_W-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/rss_timer.sv
module rss_timer #(
  parameter int unsigned SEQ_END = 98,
  parameter int unsigned CNT_W   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic armed_q;

  assign start_o = strobe_i & armed_q & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      cnt_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_o) begin
        armed_q <= 1'b0;
        busy_o  <= 1'b1;
        cnt_o   <= '0;
      end else if (busy_o) begin
        if (cnt_o == CNT_W'(SEQ_END)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end else if (!strobe_i) begin
        armed_q <= 1'b1;  // re-arm only when idle and strobe low
      end
    end
  end

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !start_o);
endmodule

// File: rtl/rss_parity.sv
module rss_parity #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0]                 word_i,
  output logic [DATA_W/rss_pkg::HALF_W-1:0] par_o
);
  localparam int unsigned NUM_H = DATA_W / rss_pkg::HALF_W;

  for (genvar h = 0; h < NUM_H; h++) begin : g_half
    assign par_o[h] = rss_pkg::odd_par(word_i[h*rss_pkg::HALF_W +: rss_pkg::HALF_W]);
  end
endmodule

// File: rtl/rss_pulse_sched.sv
module rss_pulse_sched #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAIR_W    = 2,
  parameter int unsigned NUM_PAR   = 2,
  parameter int unsigned START_DLY = 45,
  parameter int unsigned STEP_CYC  = 6,
  parameter int unsigned PULSE_CYC = 5,
  parameter int unsigned PAR_GAP   = 0,
  parameter int unsigned PAR_CYC   = 5,
  parameter int unsigned CNT_W     = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               busy_i,
  input  logic [DATA_W-1:0]  word_i,
  input  logic [NUM_PAR-1:0] par_i,
  output logic [DATA_W-1:0]  sense_n_o,
  output logic [NUM_PAR-1:0] par_n_o
);
  localparam int unsigned NUM_STEPS = DATA_W / PAIR_W;
  localparam int unsigned DATA_END  = START_DLY + NUM_STEPS * STEP_CYC;
  localparam int unsigned PAR_START = DATA_END + PAR_GAP;

  logic [NUM_STEPS-1:0] step_on;
  logic [DATA_W-1:0]    data_set;
  logic                 par_on;

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
    assign step_on[k] = busy_i
                     && (cnt_i >= CNT_W'(START_DLY + k*STEP_CYC))
                     && (cnt_i <  CNT_W'(START_DLY + k*STEP_CYC + PULSE_CYC));
    assign data_set[k*PAIR_W +: PAIR_W] = {PAIR_W{step_on[k]}} & word_i[k*PAIR_W +: PAIR_W];
  end

  assign par_on = busy_i && (cnt_i >= CNT_W'(PAR_START))
                         && (cnt_i <  CNT_W'(PAR_START + PAR_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_n_o <= '1;
      par_n_o   <= '1;
    end else begin
      sense_n_o <= ~data_set;
      par_n_o   <= ~({NUM_PAR{par_on}} & par_i);
    end
  end

  assert_set_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~sense_n_o) & ~word_i) == '0);
  assert_pair_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~sense_n_o) <= PAIR_W);
  assert_data_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_n_o != '1) |-> ($past(cnt_i) >= CNT_W'(START_DLY) && $past(cnt_i) < CNT_W'(DATA_END)));
  assert_par_after_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_n_o != '1) |-> (sense_n_o == '1));
endmodule

// File: rtl/rd_sense_seq.sv
module rd_sense_seq #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAIR_W    = 2,
  parameter int unsigned START_DLY = 45,
  parameter int unsigned STEP_CYC  = 6,
  parameter int unsigned PULSE_CYC = 5,
  parameter int unsigned PAR_GAP   = 0,
  parameter int unsigned PAR_CYC   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_strobe_i,
  input  logic [15:0]       rd_data_i,
  output logic [15:0]       sense_n_o,
  output logic [1:0]        par_n_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned NUM_PAR   = DATA_W / rss_pkg::HALF_W;
  localparam int unsigned NUM_STEPS = DATA_W / PAIR_W;
  localparam int unsigned SEQ_END   = START_DLY + NUM_STEPS*STEP_CYC + PAR_GAP + PAR_CYC;
  localparam int unsigned CNT_W     = $clog2(SEQ_END + 1);

  logic               start;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  word_q;
  logic [NUM_PAR-1:0] par;

  rss_timer #(.SEQ_END(SEQ_END), .CNT_W(CNT_W)) timer_i (
    .clk_i, .rst_ni, .strobe_i(rd_strobe_i),
    .start_o(start), .busy_o, .done_o, .cnt_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_q <= '0;
    else if (start) word_q <= rd_data_i;
  end

  rss_parity #(.DATA_W(DATA_W)) parity_i (.word_i(word_q), .par_o(par));

  rss_pulse_sched #(
    .DATA_W(DATA_W), .PAIR_W(PAIR_W), .NUM_PAR(NUM_PAR),
    .START_DLY(START_DLY), .STEP_CYC(STEP_CYC), .PULSE_CYC(PULSE_CYC),
    .PAR_GAP(PAR_GAP), .PAR_CYC(PAR_CYC), .CNT_W(CNT_W)
  ) sched_i (
    .clk_i, .rst_ni, .cnt_i(cnt), .busy_i(busy_o),
    .word_i(word_q), .par_i(par), .sense_n_o, .par_n_o
  );

  assert_par_lo_odd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_n_o[0] |-> ($countones(word_q[7:0]) % 2 == 0));
  assert_par_hi_odd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_n_o[1] |-> ($countones(word_q[15:8]) % 2 == 0));
  assert_word_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(word_q));
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sense_n_o == '1 && par_n_o == '1));
endmodule

// File: tb/rd_sense_seq_tb.sv
module rd_sense_seq_tb_top;
  localparam int S    = 45;
  localparam int STEP = 6;
  localparam int PW   = 5;
  localparam int PS   = S + 8*STEP;  // parity start (gap 0)
  localparam int PC   = 5;
  localparam int SEND = PS + PC;
  localparam int NV   = 10;
  localparam logic [15:0] VEC [NV] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'h7100,
                                       16'h2400, 16'hA5C3, 16'h0F0F, 16'h1234, 16'hFE01};

  logic clk = 0, rst_ni = 0, rd_strobe_i = 0;
  logic [15:0] rd_data_i = '0;
  logic [15:0] sense_n_o;
  logic [1:0]  par_n_o;
  logic busy_o, done_o;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  rd_sense_seq dut_i (.clk_i(clk), .rst_ni, .rd_strobe_i, .rd_data_i,
                      .sense_n_o, .par_n_o, .busy_o, .done_o);

  initial begin
    #(8*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: short strobe, 1: extra strobe + new data mid-sequence, 2: strobe held
  task automatic run_word(input logic [15:0] w, input int mode);
    int first[18], last[18], nlo[18];
    int maxlo = 0, bd_bad = 0;
    logic [17:0] lo;
    for (int b = 0; b < 18; b++) begin first[b] = -1; last[b] = -1; nlo[b] = 0; end
    @(negedge clk);
    rd_data_i = w; rd_strobe_i = 1;
    for (int j = 0; j <= SEND + 2; j++) begin
      @(negedge clk);
      lo = ~{par_n_o, sense_n_o};
      for (int b = 0; b < 18; b++) if (lo[b]) begin
        if (first[b] < 0) first[b] = j;
        last[b] = j; nlo[b]++;
      end
      if ($countones(lo[15:0]) > maxlo) maxlo = $countones(lo[15:0]);
      if (busy_o !== (j <= SEND) || done_o !== (j == SEND + 1)) bd_bad++;
      if (mode == 0 && j == 1) rd_strobe_i = 0;
      if (mode == 1) begin
        if (j == 1)  rd_strobe_i = 0;
        if (j == 20) begin rd_strobe_i = 1; rd_data_i = ~w; end
        if (j == 24) rd_strobe_i = 0;
      end
    end
    for (int b = 0; b < 16; b++) begin
      if (w[b]) chk(first[b] == S + (b/2)*STEP + 1 && nlo[b] == PW && last[b] - first[b] + 1 == PW
                    && last[b] <= PS,
                    $sformatf("R3/R4/R5 word %h bit %0d start", w, b), first[b], S + (b/2)*STEP + 1);
      else      chk(nlo[b] == 0, $sformatf("R2 word %h zero bit %0d low cycles", w, b), nlo[b], 0);
    end
    for (int h = 0; h < 2; h++) begin
      logic ep;
      ep = ($countones(w[h*8 +: 8]) % 2) == 0;
      if (ep) chk(first[16+h] == PS + 1 && nlo[16+h] == PC && last[16+h] - first[16+h] + 1 == PC,
                  $sformatf("R1/R6 word %h parity %0d start", w, h), first[16+h], PS + 1);
      else    chk(nlo[16+h] == 0, $sformatf("R1/R2 word %h parity %0d low cycles", w, h), nlo[16+h], 0);
      chk((($countones(w[h*8 +: 8]) + ((nlo[16+h] > 0) ? 1 : 0)) % 2) == 1,
          $sformatf("R1 word %h half %0d odd total", w, h), nlo[16+h] > 0, ep);
    end
    chk(maxlo <= 2, $sformatf("R4 word %h max low data lines", w), maxlo, 2);
    chk(bd_bad == 0, $sformatf("R9 word %h busy/done timing bad cycles", w), bd_bad, 0);
    if (mode == 2) begin
      int starts = 0;
      for (int j = 0; j < 12; j++) begin
        @(negedge clk);
        if (busy_o) starts++;
      end
      chk(starts == 0, "R8 held strobe restart cycles", starts, 0);
      rd_strobe_i = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R10 reset state
    rd_strobe_i = 1; rd_data_i = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(sense_n_o == 16'hFFFF && par_n_o == 2'b11, "R10 outputs idle in reset", {par_n_o, sense_n_o}, 18'h3FFFF);
    chk(busy_o == 0 && done_o == 0, "R10 busy/done in reset", {busy_o, done_o}, 0);
    rd_strobe_i = 0;
    rst_ni = 1;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && sense_n_o == 16'hFFFF, "R10 idle after reset", busy_o, 0);

    for (int i = 0; i < NV; i++) run_word(VEC[i], 0);

    // R7: mid-sequence strobe with inverted data is ignored
    run_word(16'h5A3C, 1);
    run_word(16'h0000, 1);
    // R8: strobe held across the end does not restart
    run_word(16'hC0DE, 2);
    // next read after re-arm works normally
    run_word(16'h8001, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule